// File: doc/BRIEF.md
# Dual-Path Masked GPIO Controller

This block is a general-purpose I/O controller for up to five 32-bit ports. Every port has a fast register set on a local bus. That set holds direction, bit-group mask, set, clear and pin-value registers, and it accepts byte, halfword or word writes through per-lane byte enables. Ports 0 and 1 also carry a second, legacy register set on a slower peripheral bus. Each of the two branches keeps its own direction and output-latch state.

A two-bit path-select register on the legacy bus chooses, per port, which branch drives the pad output-enable and output-value vectors of port 0 and port 1. Ports 2 and higher are always driven by the fast branch. Pad inputs pass through a two-flop synchronizer before either bus can read them. Read data on both buses is registered and appears the cycle after the request.

Top module: `gpio_dual_path`

## Requirements
- R1: After reset, all direction bits, mask bits and output latches in both branches are 0, so `pad_oe_o` and `pad_out_o` are all zero. The path-select register reads 0, which means legacy mode for ports 0 and 1.
- R2: On the fast bus, writing 1 to a bit of the set register (code 3) drives that output latch high, and writing 1 to the clear register (code 4) drives it low. Zero bits leave the latch unchanged. A read of code 3 returns the latch, and a read of code 4 returns 0.
- R3: A fast mask bit (code 1) set to 1 excludes that pin. Writes to set, clear or pin-value (code 2) leave excluded latch bits unchanged, and pin-value reads return 0 for excluded bits.
- R4: Fast writes update only the byte lanes whose enable in `fbus_be_i` is 1. Bit b of `fbus_be_i` covers data bits 8b+7..8b.
- R5: A direction bit of 1 (fast code 0, legacy code 2) makes the pin an output. `pad_oe_o[32p+i]` equals the selected branch's direction bit i of port p.
- R6: A pin-value read returns the synchronized pad level, whatever the direction. A pad change becomes visible to a read issued two cycles after the change and not to a read issued in the same cycle as the change.
- R7: The legacy set uses these codes: 0 pin value (read only), 1 set (reads return the latch), 2 direction, 3 clear (reads return 0). Writes are full-word. Only ports 0 and 1 are reachable through it.
- R8: Bit p of the legacy path-select register (code 4) set to 1 hands port p to the fast branch. The pad vectors of that port switch to the other branch's stored state in the cycle after the write.
- R9: The branches keep separate state. A latch written through one branch is not seen in reads of the other branch, and writes to both branches in the same cycle both take effect.
- R10: Fast accesses with a port index of 5 or higher are ignored, and their reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fbus_req_i | input | 1 | Fast bus access strobe |
| fbus_we_i | input | 1 | Fast bus write (1) or read (0) |
| fbus_port_i | input | 3 | Fast bus port index |
| fbus_reg_i | input | 3 | Fast register code |
| fbus_be_i | input | 4 | Fast write byte enables |
| fbus_wdata_i | input | 32 | Fast write data |
| fbus_rdata_o | output | 32 | Fast read data, one cycle after request |
| lbus_req_i | input | 1 | Legacy bus access strobe |
| lbus_we_i | input | 1 | Legacy bus write (1) or read (0) |
| lbus_port_i | input | 1 | Legacy port index (0 or 1) |
| lbus_reg_i | input | 3 | Legacy register code |
| lbus_wdata_i | input | 32 | Legacy write data |
| lbus_rdata_o | output | 32 | Legacy read data, one cycle after request |
| pad_in_i | input | 160 | Pad levels, port p at bits 32p+31..32p |
| pad_oe_o | output | 160 | Pad output enables |
| pad_out_o | output | 160 | Pad output values |

## Verification
Both buses can write the same port in one cycle. One branch owns the pins of that port, and the other only updates its own stored state. The bench issues a fast set and a legacy set to port 1 on the same clock edge with different bit patterns. It then checks that the pad output reflects only the legacy pattern while legacy mode is active, and that each bus reads back only its own pattern. After that it flips the path select and checks that the fast pattern reaches the pads in the next cycle, without a further write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PORT_W = 32;
  localparam int unsigned LANES  = PORT_W / 8;
  localparam int unsigned N_LEG  = 2;

  typedef enum logic [2:0] {
    FR_DIR  = 3'd0,
    FR_MASK = 3'd1,
    FR_PIN  = 3'd2,
    FR_SET  = 3'd3,
    FR_CLR  = 3'd4
  } fast_reg_e;

  typedef enum logic [2:0] {
    LR_PIN = 3'd0,
    LR_SET = 3'd1,
    LR_DIR = 3'd2,
    LR_CLR = 3'd3,
    LR_SEL = 3'd4
  } leg_reg_e;

  function automatic logic [PORT_W-1:0] lane_bits(input logic [LANES-1:0] be);
    logic [PORT_W-1:0] m;
    for (int b = 0; b < LANES; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_fast_port.sv
module gpio_fast_port
  import gpio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        reg_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] out_o,
  output logic [PORT_W-1:0] mask_o,
  output logic [PORT_W-1:0] rdata_o
);
  logic [PORT_W-1:0] dir_q, out_q, mask_q;
  logic [PORT_W-1:0] lane_m, wr_m;

  assign lane_m = lane_bits(be_i);
  assign wr_m   = lane_m & ~mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '0;
    end else if (wr_i) begin
      case (reg_i)
        FR_DIR:  dir_q  <= (dir_q & ~lane_m) | (wdata_i & lane_m);
        FR_MASK: mask_q <= (mask_q & ~lane_m) | (wdata_i & lane_m);
        FR_PIN:  out_q  <= (out_q & ~wr_m) | (wdata_i & wr_m);
        FR_SET:  out_q  <= out_q | (wdata_i & wr_m);
        FR_CLR:  out_q  <= out_q & ~(wdata_i & wr_m);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_i)
      FR_DIR:  rdata_o = dir_q;
      FR_MASK: rdata_o = mask_q;
      FR_PIN:  rdata_o = pin_i & ~mask_q;
      FR_SET:  rdata_o = out_q;
      default: rdata_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_legacy_port.sv
module gpio_legacy_port
  import gpio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        reg_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] out_o,
  output logic [PORT_W-1:0] rdata_o
);
  logic [PORT_W-1:0] dir_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_i) begin
      case (reg_i)
        LR_SET:  out_q <= out_q | wdata_i;
        LR_CLR:  out_q <= out_q & ~wdata_i;
        LR_DIR:  dir_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_i)
      LR_PIN:  rdata_o = pin_i;
      LR_SET:  rdata_o = out_q;
      LR_DIR:  rdata_o = dir_q;
      default: rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
endmodule

// File: rtl/gpio_dual_path.sv
module gpio_dual_path
  import gpio_pkg::*;
#(
  parameter int unsigned N_PORTS = 5,
  localparam int unsigned PIDX_W = 3,
  localparam int unsigned PADS   = N_PORTS * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fbus_req_i,
  input  logic              fbus_we_i,
  input  logic [PIDX_W-1:0] fbus_port_i,
  input  logic [2:0]        fbus_reg_i,
  input  logic [LANES-1:0]  fbus_be_i,
  input  logic [PORT_W-1:0] fbus_wdata_i,
  output logic [PORT_W-1:0] fbus_rdata_o,
  input  logic              lbus_req_i,
  input  logic              lbus_we_i,
  input  logic              lbus_port_i,
  input  logic [2:0]        lbus_reg_i,
  input  logic [PORT_W-1:0] lbus_wdata_i,
  output logic [PORT_W-1:0] lbus_rdata_o,
  input  logic [PADS-1:0]   pad_in_i,
  output logic [PADS-1:0]   pad_oe_o,
  output logic [PADS-1:0]   pad_out_o
);
  logic [PADS-1:0]   pin_s;
  logic [PORT_W-1:0] f_dir [N_PORTS];
  logic [PORT_W-1:0] f_out [N_PORTS];
  logic [PORT_W-1:0] f_msk [N_PORTS];
  logic [PORT_W-1:0] f_rd  [N_PORTS];
  logic [PORT_W-1:0] l_dir [N_LEG];
  logic [PORT_W-1:0] l_out [N_LEG];
  logic [PORT_W-1:0] l_rd  [N_LEG];
  logic [N_LEG-1:0]  sel_fast_q;
  logic              l_sel_acc;
  logic [PORT_W-1:0] f_rd_mux, l_rd_mux;

  gpio_sync #(.W(PADS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (pin_s)
  );

  assign l_sel_acc = (lbus_reg_i == LR_SEL);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic f_wr;
    assign f_wr = fbus_req_i & fbus_we_i & (fbus_port_i == PIDX_W'(p));

    gpio_fast_port u_fast (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (f_wr),
      .reg_i  (fbus_reg_i),
      .be_i   (fbus_be_i),
      .wdata_i(fbus_wdata_i),
      .pin_i  (pin_s[p*PORT_W +: PORT_W]),
      .dir_o  (f_dir[p]),
      .out_o  (f_out[p]),
      .mask_o (f_msk[p]),
      .rdata_o(f_rd[p])
    );

    if (p < N_LEG) begin : g_leg
      logic l_wr;
      assign l_wr = lbus_req_i & lbus_we_i & ~l_sel_acc & (lbus_port_i == 1'(p));

      gpio_legacy_port u_leg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (l_wr),
        .reg_i  (lbus_reg_i),
        .wdata_i(lbus_wdata_i),
        .pin_i  (pin_s[p*PORT_W +: PORT_W]),
        .dir_o  (l_dir[p]),
        .out_o  (l_out[p]),
        .rdata_o(l_rd[p])
      );

      assign pad_oe_o[p*PORT_W +: PORT_W]  = sel_fast_q[p] ? f_dir[p] : l_dir[p];
      assign pad_out_o[p*PORT_W +: PORT_W] = sel_fast_q[p] ? f_out[p] : l_out[p];
    end else begin : g_fast_only
      assign pad_oe_o[p*PORT_W +: PORT_W]  = f_dir[p];
      assign pad_out_o[p*PORT_W +: PORT_W] = f_out[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_fast_q <= '0;
    else if (lbus_req_i && lbus_we_i && l_sel_acc) sel_fast_q <= lbus_wdata_i[N_LEG-1:0];
  end

  always_comb begin
    f_rd_mux = '0;
    for (int i = 0; i < N_PORTS; i++)
      if (fbus_port_i == PIDX_W'(i)) f_rd_mux = f_rd[i];
  end

  always_comb begin
    if (l_sel_acc) l_rd_mux = {{(PORT_W-N_LEG){1'b0}}, sel_fast_q};
    else           l_rd_mux = l_rd[lbus_port_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fbus_rdata_o <= '0;
      lbus_rdata_o <= '0;
    end else begin
      if (fbus_req_i && !fbus_we_i) fbus_rdata_o <= f_rd_mux;
      if (lbus_req_i && !lbus_we_i) lbus_rdata_o <= l_rd_mux;
    end
  end
endmodule

// File: rtl/gpio_dual_path_chk.sv
module gpio_dual_path_chk
  import gpio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fbus_req_i,
  input logic              fbus_we_i,
  input logic [2:0]        fbus_port_i,
  input logic [2:0]        fbus_reg_i,
  input logic [PORT_W-1:0] fbus_rdata_o,
  input logic              lbus_req_i,
  input logic              lbus_we_i,
  input logic [N_LEG-1:0]  sel_fast,
  input logic [PORT_W-1:0] fast_out0,
  input logic [PORT_W-1:0] leg_dir0,
  input logic [PORT_W-1:0] pad_oe0,
  input logic [PORT_W-1:0] fast_out2,
  input logic [PORT_W-1:0] fast_mask2
);
  // R1
  reset_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> sel_fast == '0);

  // R2
  clear_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fbus_req_i && !fbus_we_i && fbus_reg_i == 3'd4) |=> fbus_rdata_o == '0);

  // R3
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fbus_req_i && fbus_we_i && fbus_port_i == 3'd2 && fbus_reg_i != 3'd1)
      |=> ((fast_out2 ^ $past(fast_out2)) & $past(fast_mask2)) == '0);

  // R8
  legacy_owns_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_fast[0] |-> pad_oe0 == leg_dir0);

  // R9
  fast_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lbus_req_i && lbus_we_i && !fbus_req_i) |=> $stable(fast_out0));
endmodule

bind gpio_dual_path gpio_dual_path_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fbus_req_i  (fbus_req_i),
  .fbus_we_i   (fbus_we_i),
  .fbus_port_i (fbus_port_i),
  .fbus_reg_i  (fbus_reg_i),
  .fbus_rdata_o(fbus_rdata_o),
  .lbus_req_i  (lbus_req_i),
  .lbus_we_i   (lbus_we_i),
  .sel_fast    (sel_fast_q),
  .fast_out0   (f_out[0]),
  .leg_dir0    (l_dir[0]),
  .pad_oe0     (pad_oe_o[31:0]),
  .fast_out2   (f_out[2]),
  .fast_mask2  (f_msk[2])
);

// File: tb/gpio_dual_path_tb.sv
module gpio_dual_path_tb_top;
  localparam int NP = 5;
  localparam int PADS = NP * 32;

  logic clk_i = 0, rst_ni = 0;
  logic fbus_req_i = 0, fbus_we_i = 0;
  logic [2:0] fbus_port_i = 0, fbus_reg_i = 0;
  logic [3:0] fbus_be_i = 0;
  logic [31:0] fbus_wdata_i = 0, fbus_rdata_o;
  logic lbus_req_i = 0, lbus_we_i = 0, lbus_port_i = 0;
  logic [2:0] lbus_reg_i = 0;
  logic [31:0] lbus_wdata_i = 0, lbus_rdata_o;
  logic [PADS-1:0] pad_in_i = '0, pad_oe_o, pad_out_o;

  int checks = 0, failures = 0;
  logic done = 0;

  always #5 clk_i = ~clk_i;

  gpio_dual_path dut_i (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic fwr(input int port, input int rg, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    fbus_req_i = 1; fbus_we_i = 1; fbus_port_i = 3'(port); fbus_reg_i = 3'(rg);
    fbus_be_i = be; fbus_wdata_i = d;
    @(negedge clk_i);
    fbus_req_i = 0; fbus_we_i = 0;
  endtask

  task automatic frd(input int port, input int rg, output logic [31:0] d);
    @(negedge clk_i);
    fbus_req_i = 1; fbus_we_i = 0; fbus_port_i = 3'(port); fbus_reg_i = 3'(rg);
    @(negedge clk_i);
    fbus_req_i = 0;
    d = fbus_rdata_o;
  endtask

  task automatic lwr(input int port, input int rg, input logic [31:0] d);
    @(negedge clk_i);
    lbus_req_i = 1; lbus_we_i = 1; lbus_port_i = 1'(port); lbus_reg_i = 3'(rg); lbus_wdata_i = d;
    @(negedge clk_i);
    lbus_req_i = 0; lbus_we_i = 0;
  endtask

  task automatic lrd(input int port, input int rg, output logic [31:0] d);
    @(negedge clk_i);
    lbus_req_i = 1; lbus_we_i = 0; lbus_port_i = 1'(port); lbus_reg_i = 3'(rg);
    @(negedge clk_i);
    lbus_req_i = 0;
    d = lbus_rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 oe", pad_oe_o[31:0] | pad_oe_o[159:128], 0);
    chk("R1 out", pad_out_o[63:32] | pad_out_o[95:64], 0);
    frd(3, 0, d); chk("R1 fast dir", d, 0);
    frd(3, 1, d); chk("R1 fast mask", d, 0);
    lrd(0, 4, d); chk("R1 select", d, 0);
  endtask

  task automatic t_legacy;
    logic [31:0] d;
    lwr(0, 2, 32'hFFFF0000);
    chk("R5 legacy oe", pad_oe_o[31:0], 32'hFFFF0000);
    lwr(0, 1, 32'hA5A50000);
    chk("R7 legacy set", pad_out_o[31:0], 32'hA5A50000);
    lwr(0, 3, 32'h05050000);
    chk("R7 legacy clear", pad_out_o[31:0], 32'hA0A00000);
    lrd(0, 1, d); chk("R7 set readback", d, 32'hA0A00000);
    lrd(0, 3, d); chk("R7 clear reads 0", d, 0);
  endtask

  task automatic t_fast;
    logic [31:0] d;
    fwr(2, 0, 4'hF, 32'h0000FFFF);
    chk("R5 fast oe", pad_oe_o[95:64], 32'h0000FFFF);
    fwr(2, 3, 4'hF, 32'h000000F0);
    chk("R2 set", pad_out_o[95:64], 32'h000000F0);
    fwr(2, 4, 4'hF, 32'h00000030);
    chk("R2 clear", pad_out_o[95:64], 32'h000000C0);
    frd(2, 4, d); chk("R2 clear reads 0", d, 0);
    frd(2, 3, d); chk("R2 set readback", d, 32'h000000C0);
    fwr(2, 2, 4'b0010, 32'hFFFFFFFF);
    chk("R4 byte lane", pad_out_o[95:64], 32'h0000FFC0);
    fwr(2, 0, 4'b1100, 32'hFFFFFFFF);
    chk("R4 halfword dir", pad_oe_o[95:64], 32'hFFFFFFFF);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    fwr(3, 1, 4'hF, 32'h0000FFFF);
    fwr(3, 3, 4'hF, 32'hFFFFFFFF);
    chk("R3 masked set", pad_out_o[127:96], 32'hFFFF0000);
    fwr(3, 4, 4'hF, 32'hFFFFFFFF);
    chk("R3 masked clear", pad_out_o[127:96], 0);
    pad_in_i[127:96] = 32'hFFFFFFFF;
    repeat (3) @(negedge clk_i);
    frd(3, 2, d); chk("R3 masked pin read", d, 32'hFFFF0000);
  endtask

  task automatic t_sync;
    logic [31:0] d;
    @(negedge clk_i);
    pad_in_i[159:128] = 32'h12345678;
    frd(4, 2, d); chk("R6 not yet synced", d, 0);
    @(negedge clk_i);
    frd(4, 2, d); chk("R6 synced read", d, 32'h12345678);
    fwr(4, 0, 4'hF, 32'hFFFFFFFF);
    frd(4, 2, d); chk("R6 read as output", d, 32'h12345678);
  endtask

  task automatic t_dual;
    logic [31:0] d;
    @(negedge clk_i);
    fbus_req_i = 1; fbus_we_i = 1; fbus_port_i = 1; fbus_reg_i = 3; fbus_be_i = 4'hF;
    fbus_wdata_i = 32'h000000FF;
    lbus_req_i = 1; lbus_we_i = 1; lbus_port_i = 1; lbus_reg_i = 1; lbus_wdata_i = 32'h00FF0000;
    @(negedge clk_i);
    fbus_req_i = 0; lbus_req_i = 0; fbus_we_i = 0; lbus_we_i = 0;
    chk("R9 legacy drives pads", pad_out_o[63:32], 32'h00FF0000);
    lrd(1, 1, d); chk("R9 legacy isolated", d, 32'h00FF0000);
    frd(1, 3, d); chk("R9 fast isolated", d, 32'h000000FF);
    lwr(0, 4, 32'h2);
    chk("R8 switch to fast", pad_out_o[63:32], 32'h000000FF);
    chk("R8 port0 stays legacy", pad_out_o[31:0], 32'hA0A00000);
    lwr(0, 4, 32'h0);
    chk("R8 switch back", pad_out_o[63:32], 32'h00FF0000);
  endtask

  task automatic t_range;
    logic [31:0] d;
    fwr(5, 0, 4'hF, 32'hFFFFFFFF);
    frd(5, 0, d); chk("R10 bad port read", d, 0);
    chk("R10 no pad change", pad_oe_o[159:128], 32'hFFFFFFFF);
    frd(7, 2, d); chk("R10 bad port pin", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_legacy();
    t_fast();
    t_mask();
    t_sync();
    t_dual();
    t_range();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule